// File: doc/BRIEF.md
# Transmit Descriptor Ring Gatherer

This block is a transmit DMA engine. Software builds a ring of two-word descriptors in memory, points the engine at the ring, and hands over each descriptor by setting its ownership bit. The engine polls the current descriptor. When it owns that descriptor, it walks the chain that starts there and reads each buffer over a word-wide memory master port. It sends the bytes out as a single valid/ready byte stream, and the last byte of the packet carries a last marker.

When a chain is finished, the engine gives its descriptors back to software. Each chained descriptor gets its flag word cleared to zero as it is consumed. The descriptor that opened the chain keeps its flags and has only its ownership bit cleared, after all the others. A one-cycle completion interrupt then fires. Two registers sit on a small write/read interface: the ring base and the current descriptor pointer. The current pointer advances as descriptors are consumed. A one-byte staging register holds back the newest byte, so the last marker can be placed correctly even when the chain ends with zero-length descriptors.

Top module: `txring_gather`

## Requirements
- R1: A write to register offset 0x04 sets the ring base, and a write to offset 0x08 sets the current descriptor pointer. `reg_rdata` returns the register selected by `reg_addr` one cycle later. Any other offset reads as zero.
- R2: While the ring base is zero, the engine makes no memory access.
- R3: Bit 31 of a descriptor's word 0 is the ownership bit. If the descriptor opening a chain is not owned, nothing is sent and no interrupt fires. The engine reads that descriptor again after `POLL_CYCLES` idle cycles.
- R4: Each descriptor is two 32-bit words 8 bytes apart. Word 0 holds the flags and holds the byte count in bits 12:0. Word 1 (address + 4) holds the buffer address. Bytes go out in address order, and the byte at address A comes from byte lane A[1:0] of the word at A with bits 1:0 cleared (lane 0 = bits 7:0). `out_last` marks only the final byte of the packet. A descriptor with count zero adds no bytes but is still consumed.
- R5: When word 0 bit 27 is set, the packet continues in the next descriptor. When word 0 bit 30 is set, the next descriptor is the ring base; otherwise it is the current address + 8. After each consumed descriptor, the current pointer register holds that next address.
- R6: Word 0 of every chained (non-first) descriptor is overwritten with zero once it is consumed.
- R7: When a chain completes, the first descriptor's word 0 is written back with only bit 31 cleared. The interrupt `irq` is then high for exactly one cycle.
- R8: A chain whose total count is zero sends no bytes and still raises the interrupt.
- R9: A chained descriptor found not owned aborts the packet. Any bytes already gathered end with `out_last` and `out_err` set. Nothing is written back, no interrupt fires, and the current pointer stays on the unowned descriptor.
- R10: A buffer address whose bits 31:30 are both 1 has those two bits cleared before it is fetched. Any other address is used unchanged.
- R11: At most `MAX_PKT` bytes of a chain are sent. The extra bytes are read and discarded, and the final byte carries `out_err`. `out_err` is only ever set together with `out_last`.
- R12: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_last` and `out_err` hold their values.
- R13: After reset, `out_valid`, `irq` and `mem_req` are low, and both registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access completes this cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the packet |
| out_err | output | 1 | Packet truncated or aborted (with `out_last`) |
| out_ready | input | 1 | Downstream accepts the byte |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the rules that hold cycle by cycle: the output holds steady under back-pressure, a memory request holds its address until acknowledged, no write-back ever carries a set ownership bit, the interrupt is a single pulse, no access starts while the ring base is zero, an error flag never appears without the last marker, and no fetch uses an address with both top bits set. Everything else can only be shown by whole scenarios, so the bench checks it against its own model of the ring: the gathered byte order, the placement of the last marker, the chain-walking and wrap order, the write-back contents, the re-poll interval, abort and truncation.

// File: rtl/txg_pkg.sv
package txg_pkg;
  localparam int WORD_W     = 32;
  localparam int BYTE_W     = 8;
  localparam int CNT_W      = 13;
  localparam int OWN_BIT    = 31;
  localparam int WRAP_BIT   = 30;
  localparam int CONT_BIT   = 27;
  localparam int DESC_BYTES = 8;
  localparam int PTR_OFS    = 4;
  localparam int OFS_BASE   = 4;
  localparam int OFS_CUR    = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_W0, S_RD_W1, S_RD_BUF, S_EMIT,
    S_WB_ZERO, S_ADV, S_CLOSE, S_WB_FIRST, S_ABORT
  } txg_state_e;
endpackage

// File: rtl/txg_regs.sv
module txg_regs import txg_pkg::*; #(
  parameter int AW     = 32,
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              cur_ld,
  input  logic [AW-1:0]     cur_nxt,
  output logic [AW-1:0]     ring_base,
  output logic [AW-1:0]     cur_ptr
);
  localparam logic [REG_AW-1:0] A_BASE = REG_AW'(OFS_BASE);
  localparam logic [REG_AW-1:0] A_CUR  = REG_AW'(OFS_CUR);

  // software write to the pointer wins over engine advance
  always_ff @(posedge clk) begin
    if (rst) begin
      ring_base <= '0;
      cur_ptr   <= '0;
      reg_rdata <= '0;
    end else begin
      if (cur_ld) cur_ptr <= cur_nxt;
      if (reg_we && reg_addr == A_BASE) ring_base <= reg_wdata[AW-1:0];
      if (reg_we && reg_addr == A_CUR)  cur_ptr   <= reg_wdata[AW-1:0];
      case (reg_addr)
        A_BASE:  reg_rdata <= WORD_W'(ring_base);
        A_CUR:   reg_rdata <= WORD_W'(cur_ptr);
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/txg_stage.sv
module txg_stage import txg_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [BYTE_W-1:0] push_byte,
  input  logic              close,
  input  logic              close_err,
  output logic              can_push,
  output logic              close_done,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last,
  output logic              out_err,
  input  logic              out_ready
);
  logic              pend_v;
  logic [BYTE_W-1:0] pend_b;
  logic              out_free;

  assign out_free   = !out_valid || out_ready;
  assign can_push   = !pend_v || out_free;
  assign close_done = !pend_v || out_free;

  // newest byte is held back until it is known whether it ends the packet
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v    <= 1'b0;
      pend_b    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (push && can_push) begin
        if (pend_v) begin
          out_valid <= 1'b1;
          out_data  <= pend_b;
          out_last  <= 1'b0;
          out_err   <= 1'b0;
        end
        pend_b <= push_byte;
        pend_v <= 1'b1;
      end else if (close && pend_v && out_free) begin
        out_valid <= 1'b1;
        out_data  <= pend_b;
        out_last  <= 1'b1;
        out_err   <= close_err;
        pend_v    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/txring_gather.sv
module txring_gather import txg_pkg::*; #(
  parameter int AW          = 32,
  parameter int REG_AW      = 8,
  parameter int MAX_PKT     = 8192,
  parameter int POLL_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              out_err,
  input  logic              out_ready,
  output logic              irq
);
  localparam int TOT_W  = $clog2(MAX_PKT + 1);
  localparam int WAIT_W = $clog2(POLL_CYCLES + 1);
  localparam logic [AW-1:0]     STRIDE  = AW'(DESC_BYTES);
  localparam logic [AW-1:0]     W1_OFS  = AW'(PTR_OFS);
  localparam logic [TOT_W-1:0]  TOT_MAX = TOT_W'(MAX_PKT);
  localparam logic [WAIT_W-1:0] WAIT_LD = WAIT_W'(POLL_CYCLES);

  txg_state_e        state_q;
  logic [AW-1:0]     ring_base, cur_ptr, cur_nxt;
  logic              cur_ld;
  logic [AW-1:0]     desc_q, first_addr_q, baddr_q;
  logic [31:0]       first_w0_q, word_q;
  logic              wrap_q, cont_q, is_first_q, trunc_q, irq_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [TOT_W-1:0]  tot_q;
  logic [WAIT_W-1:0] wait_q;

  logic              push, close, close_err, can_push, close_done, keep, step;
  logic [1:0]        lane;
  logic [7:0]        cur_byte;
  logic [AW-1:0]     nxt_desc;

  function automatic logic [AW-1:0] remap(input logic [AW-1:0] a);
    remap = (a[AW-1:AW-2] == 2'b11) ? {2'b00, a[AW-3:0]} : a;
  endfunction

  txg_regs #(.AW(AW), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cur_ld(cur_ld),
    .cur_nxt(cur_nxt), .ring_base(ring_base), .cur_ptr(cur_ptr)
  );

  txg_stage u_stage (
    .clk(clk), .rst(rst), .push(push), .push_byte(cur_byte),
    .close(close), .close_err(close_err), .can_push(can_push),
    .close_done(close_done), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_err(out_err), .out_ready(out_ready)
  );

  assign lane      = baddr_q[1:0];
  assign cur_byte  = word_q[{lane, 3'b000} +: 8];
  assign keep      = !trunc_q && (tot_q < TOT_MAX);
  assign push      = (state_q == S_EMIT) && keep;
  assign step      = (state_q == S_EMIT) && (!keep || can_push);
  assign close     = (state_q == S_CLOSE) || (state_q == S_ABORT);
  assign close_err = (state_q == S_ABORT) || trunc_q;
  assign nxt_desc  = wrap_q ? ring_base : desc_q + STRIDE;
  assign cur_ld    = (state_q == S_ADV);
  assign cur_nxt   = nxt_desc;
  assign irq       = irq_q;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = desc_q;
    mem_wdata = '0;
    case (state_q)
      S_RD_W0:    mem_req = 1'b1;
      S_RD_W1:    begin mem_req = 1'b1; mem_addr = desc_q + W1_OFS; end
      S_RD_BUF:   begin mem_req = 1'b1; mem_addr = {baddr_q[AW-1:2], 2'b00}; end
      S_WB_ZERO:  begin mem_req = 1'b1; mem_we = 1'b1; end
      S_WB_FIRST: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = first_addr_q;
        mem_wdata = first_w0_q & ~(32'd1 << OWN_BIT);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      desc_q       <= '0;
      first_addr_q <= '0;
      first_w0_q   <= '0;
      baddr_q      <= '0;
      word_q       <= '0;
      wrap_q       <= 1'b0;
      cont_q       <= 1'b0;
      is_first_q   <= 1'b0;
      trunc_q      <= 1'b0;
      irq_q        <= 1'b0;
      cnt_q        <= '0;
      tot_q        <= '0;
      wait_q       <= '0;
    end else begin
      irq_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
          end else if (ring_base != '0) begin
            desc_q     <= cur_ptr;
            is_first_q <= 1'b1;
            tot_q      <= '0;
            trunc_q    <= 1'b0;
            state_q    <= S_RD_W0;
          end
        end
        S_RD_W0: if (mem_ack) begin
          wrap_q <= mem_rdata[WRAP_BIT];
          cont_q <= mem_rdata[CONT_BIT];
          cnt_q  <= mem_rdata[CNT_W-1:0];
          if (!mem_rdata[OWN_BIT]) begin
            if (is_first_q) begin
              wait_q  <= WAIT_LD;
              state_q <= S_IDLE;
            end else begin
              state_q <= S_ABORT;
            end
          end else begin
            if (is_first_q) begin
              first_addr_q <= desc_q;
              first_w0_q   <= mem_rdata;
            end
            state_q <= S_RD_W1;
          end
        end
        S_RD_W1: if (mem_ack) begin
          baddr_q <= remap(mem_rdata[AW-1:0]);
          if (cnt_q == '0) state_q <= is_first_q ? S_ADV : S_WB_ZERO;
          else             state_q <= S_RD_BUF;
        end
        S_RD_BUF: if (mem_ack) begin
          word_q  <= mem_rdata;
          state_q <= S_EMIT;
        end
        S_EMIT: if (step) begin
          cnt_q   <= cnt_q - 1'b1;
          baddr_q <= baddr_q + 1'b1;
          if (keep) tot_q   <= tot_q + 1'b1;
          else      trunc_q <= 1'b1;
          if (cnt_q == CNT_W'(1)) state_q <= is_first_q ? S_ADV : S_WB_ZERO;
          else if (lane == 2'd3)  state_q <= S_RD_BUF;
        end
        S_WB_ZERO: if (mem_ack) state_q <= S_ADV;
        S_ADV: begin
          desc_q <= nxt_desc;
          if (cont_q) begin
            is_first_q <= 1'b0;
            state_q    <= S_RD_W0;
          end else begin
            state_q <= S_CLOSE;
          end
        end
        S_CLOSE: if (close_done) state_q <= S_WB_FIRST;
        S_WB_FIRST: if (mem_ack) begin
          irq_q   <= 1'b1;
          wait_q  <= '0;
          state_q <= S_IDLE;
        end
        S_ABORT: if (close_done) begin
          wait_q  <= WAIT_LD;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txg_checker.sv
module txg_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ack,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic          out_last,
  input logic          out_err,
  input logic          irq,
  input logic [AW-1:0] ring_base
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last) && $stable(out_err)); // R12
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R4
  AST_WB_NO_OWN: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> !mem_wdata[31]); // R7
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R7
  AST_ERR_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_err |-> out_last); // R11
  AST_NO_HIGH_FETCH: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_we |-> mem_addr[AW-1:AW-2] != 2'b11); // R10
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> ring_base != '0); // R2
endmodule

bind txring_gather txg_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last), .out_err(out_err), .irq(irq), .ring_base(ring_base)
);

// File: tb/tb_txring_gather.sv
module tb_txring_gather;
  localparam int CLK_P = 10;
  localparam int MAXP  = 64;
  localparam int POLL  = 16;
  localparam int RING  = 'h40;
  localparam int SLOTS = 16;

  logic clk = 0, rst = 1;
  logic reg_we = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic out_valid, out_last, out_err, out_ready = 1, irq;
  logic [7:0] out_data;

  txring_gather #(.AW(32), .REG_AW(8), .MAX_PKT(MAXP), .POLL_CYCLES(POLL)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .out_err(out_err),
    .out_ready(out_ready), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  logic [31:0] mem [0:1023];
  assign mem_rdata = mem[mem_addr[11:2]];

  int nchk = 0, nfail = 0;
  logic [7:0] exp_q[$], rx_q[$];
  bit rx_last_q[$], rx_err_q[$];
  bit exp_err;
  int irq_cnt = 0, rd_cnt = 0, hi11_cnt = 0, hi10_cnt = 0, poll_cnt = 0, stall_bad = 0;
  int poll_addr = -1;
  int bp, buf_ptr, first_addr;
  logic [31:0] first_w0;
  int d_addr[$];

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model with random acknowledge latency
  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    forever begin
      @(posedge clk);
      if (mem_req && mem_ack && mem_we) mem[mem_addr[11:2]] = mem_wdata;
      mem_ack <= mem_req && !mem_ack && ($urandom_range(0, 3) != 0);
    end
  end

  // output collector, back-pressure and monitors
  initial begin
    bit st_prev = 0;
    logic [9:0] st_val = 0;
    forever begin
      @(negedge clk);
      out_ready = ($urandom_range(0, 3) != 0);
      if (st_prev && (!out_valid || {out_data, out_last, out_err} !== st_val)) stall_bad++;
      if (out_valid && out_ready) begin
        rx_q.push_back(out_data);
        rx_last_q.push_back(out_last);
        rx_err_q.push_back(out_err);
      end
      st_prev = out_valid && !out_ready;
      st_val = {out_data, out_last, out_err};
      if (mem_req && mem_ack && !mem_we) begin
        rd_cnt++;
        if (mem_addr[31:30] == 2'b11) hi11_cnt++;
        if (mem_addr[31:30] == 2'b10) hi10_cnt++;
        if (mem_addr == poll_addr) poll_cnt++;
      end
      if (irq) irq_cnt++;
    end
  end

  task automatic reg_write(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic new_chain();
    exp_q.delete(); rx_q.delete(); rx_last_q.delete(); rx_err_q.delete();
    d_addr.delete();
    buf_ptr = 'h400 + $urandom_range(0, 3);
    exp_err = 0;
  endtask

  // descriptor: bit31 own, bit30 wrap, bit27 continue, bits 12:0 count
  task automatic add_desc(input int len, input bit cont, input bit own, input logic [1:0] hi);
    bit wrap = (bp == RING + (SLOTS - 1) * 8);
    logic [31:0] w0 = (32'(own) << 31) | (32'(wrap) << 30) | (32'(cont) << 27) | 32'(len);
    mem[(bp + 4) >> 2] = {hi, 30'(buf_ptr)};
    for (int k = 0; k < len; k++) begin
      logic [7:0] b = 8'($urandom);
      int a = buf_ptr + k;
      mem[a >> 2][(a & 3) * 8 +: 8] = b;
      if (exp_q.size() < MAXP) exp_q.push_back(b); else exp_err = 1;
    end
    if (d_addr.size() == 0) begin
      first_addr = bp; first_w0 = w0;
      mem[bp >> 2] = w0 & 32'h7fffffff;
    end else begin
      mem[bp >> 2] = w0;
    end
    d_addr.push_back(bp);
    buf_ptr += len;
    bp = wrap ? RING : bp + 8;
  endtask

  task automatic go();
    @(negedge clk); mem[first_addr >> 2] = first_w0;
  endtask

  task automatic wait_irq(input int base);
    for (int i = 0; i < 4000 && irq_cnt <= base; i++) @(negedge clk);
    repeat (30) @(negedge clk);
  endtask

  task automatic check_done(input string tag);
    int bad = 0, nl = 0;
    logic [31:0] v;
    for (int i = 0; i < exp_q.size() && i < rx_q.size(); i++) if (rx_q[i] !== exp_q[i]) bad++;
    for (int i = 0; i < rx_last_q.size(); i++) nl += rx_last_q[i];
    chk(rx_q.size() == exp_q.size(), "R4", {tag, " byte count"}, rx_q.size(), exp_q.size());
    chk(bad == 0, "R4", {tag, " byte values"}, bad, 0);
    chk(nl == (exp_q.size() > 0 ? 1 : 0) && (rx_q.size() == 0 || rx_last_q[rx_q.size()-1]),
        "R4", {tag, " last marker"}, nl, exp_q.size() > 0);
    if (rx_q.size() > 0)
      chk(rx_err_q[rx_q.size()-1] == exp_err, "R11", {tag, " error flag"}, rx_err_q[rx_q.size()-1], exp_err);
    chk(mem[first_addr >> 2] == (first_w0 & 32'h7fffffff), "R7", {tag, " first write-back"},
        mem[first_addr >> 2], first_w0 & 32'h7fffffff);
    for (int i = 1; i < d_addr.size(); i++)
      chk(mem[d_addr[i] >> 2] == 0, "R6", {tag, " chained release"}, mem[d_addr[i] >> 2], 0);
    reg_read(8'h08, v);
    chk(v == bp, "R5", {tag, " current pointer"}, v, bp);
  endtask

  task automatic run_chain(input string tag);
    int base = irq_cnt;
    go();
    wait_irq(base);
    chk(irq_cnt == base + 1, "R7", {tag, " interrupt count"}, irq_cnt - base, 1);
    check_done(tag);
  endtask

  initial begin
    repeat (1500000 / CLK_P) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!out_valid && !irq && !mem_req, "R13", "outputs after reset", {out_valid, irq, mem_req}, 0);
    reg_read(8'h04, v);
    chk(v == 0, "R13", "base after reset", v, 0);
    reg_read(8'h08, v);
    chk(v == 0, "R13", "pointer after reset", v, 0);

    // engine disabled while base is zero
    bp = RING;
    new_chain(); add_desc(4, 0, 1, 2'b00); go();
    reg_write(8'h08, RING);
    repeat (60) @(negedge clk);
    chk(rd_cnt == 0, "R2", "reads with zero base", rd_cnt, 0);
    reg_read(8'h08, v);
    chk(v == RING, "R1", "pointer readback", v, RING);
    base = irq_cnt;
    reg_write(8'h04, RING);
    reg_read(8'h04, v);
    chk(v == RING, "R1", "base readback", v, RING);
    reg_read(8'h0C, v);
    chk(v == 0, "R1", "unmapped offset", v, 0);
    wait_irq(base);
    chk(irq_cnt == base + 1, "R7", "first packet interrupt", irq_cnt - base, 1);
    check_done("single");

    // re-poll of unowned descriptor
    new_chain(); add_desc(6, 0, 1, 2'b00);
    poll_cnt = 0; poll_addr = first_addr; base = irq_cnt;
    repeat (120) @(negedge clk);
    chk(poll_cnt >= 3 && poll_cnt <= 8, "R3", "poll reads in window", poll_cnt, 6);
    chk(irq_cnt == base && rx_q.size() == 0, "R3", "nothing sent while unowned", rx_q.size(), 0);
    poll_addr = -1;
    run_chain("after poll");

    // zero-length descriptors in a chain
    new_chain(); add_desc(7, 1, 1, 2'b00); add_desc(0, 1, 1, 2'b00); add_desc(5, 0, 1, 2'b00);
    run_chain("zero middle");

    // zero total length
    new_chain(); add_desc(0, 1, 1, 2'b00); add_desc(0, 0, 1, 2'b00);
    run_chain("R8 zero total");
    chk(rx_q.size() == 0, "R8", "no bytes sent", rx_q.size(), 0);

    // buffer address remap
    hi11_cnt = 0; hi10_cnt = 0;
    new_chain(); add_desc(5, 1, 1, 2'b11); add_desc(6, 0, 1, 2'b10);
    run_chain("R10 remap");
    chk(hi11_cnt == 0, "R10", "fetches with both top bits", hi11_cnt, 0);
    chk(hi10_cnt > 0, "R10", "single top bit kept", hi10_cnt, 1);

    // wrap to ring base
    bp = RING + (SLOTS - 1) * 8;
    reg_write(8'h08, bp);
    repeat (40) @(negedge clk);
    new_chain(); add_desc(3, 1, 1, 2'b00); add_desc(4, 0, 1, 2'b00);
    run_chain("R5 wrap");
    chk(bp == RING + 8, "R5", "bench wrap model", bp, RING + 8);

    // truncation
    new_chain();
    for (int i = 0; i < 4; i++) add_desc(20, i != 3, 1, 2'b00);
    run_chain("R11 truncate");
    chk(exp_err == 1, "R11", "model expects truncation", exp_err, 1);

    // abort on unowned chained descriptor
    new_chain(); add_desc(5, 1, 1, 2'b00); add_desc(4, 0, 0, 2'b00);
    base = irq_cnt;
    go();
    repeat (300) @(negedge clk);
    chk(rx_q.size() == 5 && rx_last_q[4] && rx_err_q[4], "R9", "aborted bytes end with error",
        rx_q.size(), 5);
    chk(irq_cnt == base, "R9", "no interrupt on abort", irq_cnt - base, 0);
    chk(mem[first_addr >> 2] == first_w0, "R9", "first not written back", mem[first_addr >> 2], first_w0);
    reg_read(8'h08, v);
    chk(v == d_addr[1], "R9", "pointer on unowned", v, d_addr[1]);
    bp = d_addr[1];

    // random chains
    for (int r = 0; r < 8; r++) begin
      int n = $urandom_range(1, 3);
      new_chain();
      for (int i = 0; i < n; i++) add_desc($urandom_range(0, 20), i != n - 1, 1, 2'b00);
      run_chain($sformatf("random %0d", r));
    end

    chk(stall_bad == 0, "R12", "output held under back-pressure", stall_bad, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule